// File: doc/BRIEF.md
# Endian-Aware Output Bus Matcher

This block takes 36-bit words from the read side of a FIFO and hands them to a consumer whose bus may be narrower. It holds one word at a time and delivers it as a single 36-bit part, as two 18-bit halves, or as four 9-bit bytes. The consumer pulls each part with a read enable. A fresh word is taken from upstream only once every part of the held word has been read.

Two width pins and an endian pin are sampled while reset is asserted and then frozen inside the block. Little-endian order sends the lowest slice of the stored word first. Big-endian order sends the highest slice first. In the narrow modes the unused high lines of the output carry zero, and the output carries zero whenever no part is on offer.

Top module: `bus_width_matcher`

## Requirements
- R1: During and after reset, `outValid` is 0, `inReady` is 1 and `outData` is zero. A reset also discards any partly read word.
- R2: With `cfgNarrow`=0 (full width), a word accepted on an `inValid`&`inReady` edge appears whole on `outData` with `outValid`=1 from the next cycle. One read releases it.
- R3: With `cfgNarrow`=1 and `cfgByte`=0 (half width), a word yields two 18-bit parts on `outData[17:0]`. The slices are bits 17:0 and bits 35:18.
- R4: With `cfgNarrow`=1 and `cfgByte`=1 (byte width), a word yields four 9-bit parts on `outData[8:0]`. Slice k is bits 9k+8:9k.
- R5: With `cfgBigEnd`=1, the parts come out from the highest slice down to the lowest.
- R6: With `cfgBigEnd`=0, the parts come out from the lowest slice up to the highest.
- R7: In half width, `outData[35:18]` is zero. In byte width, `outData[35:9]` is zero.
- R8: `inReady` stays 0 until the last part of the held word has been read. Upstream data offered before then is not taken.
- R9: The width and endian pins act only as they stood during reset. Changing them afterwards has no effect until the next reset.
- R10: While `outValid`=1 and `outRdEn`=0, the part on `outData` holds steady. An `outRdEn` pulse while `outValid`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; samples the configuration pins |
| cfgNarrow | input | 1 | 0 selects full width; 1 selects a narrow width |
| cfgByte | input | 1 | When narrow: 1 selects bytes, 0 selects halves |
| cfgBigEnd | input | 1 | 1 sends the high slice first, 0 sends the low slice first |
| inValid | input | 1 | Upstream word present |
| inData | input | 36 | Upstream word |
| inReady | output | 1 | Block can take a word this cycle |
| outRdEn | input | 1 | Consumer takes the offered part |
| outValid | output | 1 | A part is offered on outData |
| outData | output | 36 | Offered part, zero-extended |

## Verification
The checker keeps its own copy of the width selection, sampled during reset, so it relies on the width pins being settled before reset is released. It also relies on the consumer never raising `outRdEn` in a way that breaks the valid/read handshake. The stimulus changes the configuration pins only with reset asserted, except in the one scenario that tests that later changes are ignored. In that scenario the checker's own frozen copy keeps its properties valid. All inputs change on falling edges.

// File: rtl/bus_width_matcher_pkg.sv
package bus_width_matcher_pkg;
  localparam int PARTS = 4;
  localparam int SEL_W = $clog2(PARTS);

  typedef enum logic [1:0] {
    MODE_FULL = 2'd0,
    MODE_HALF = 2'd1,
    MODE_BYTE = 2'd2
  } widthMode_t;

  typedef struct packed {
    logic             load;
    logic             show;
    widthMode_t       mode;
    logic [SEL_W-1:0] sel;
  } ctlStrobes_t;

  function automatic widthMode_t decodeMode(input logic narrow, input logic byteSel);
    if (!narrow) return MODE_FULL;
    return byteSel ? MODE_BYTE : MODE_HALF;
  endfunction
endpackage

// File: rtl/bus_width_matcher_ctrl.sv
module bus_width_matcher_ctrl
  import bus_width_matcher_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgNarrow,
  input  logic        cfgByte,
  input  logic        cfgBigEnd,
  input  logic        inValid,
  input  logic        outRdEn,
  output logic        inReady,
  output logic        outValid,
  output ctlStrobes_t ctl
);
  widthMode_t       modeQ;
  logic             bigEndQ;
  logic             holdValid;
  logic [SEL_W-1:0] partCnt;
  logic [SEL_W-1:0] lastIdx;
  logic             load;
  logic             advance;

  always_comb begin
    unique case (modeQ)
      MODE_HALF: lastIdx = SEL_W'(1);
      MODE_BYTE: lastIdx = SEL_W'(PARTS - 1);
      default:   lastIdx = '0;
    endcase
  end

  assign load    = inValid && !holdValid;
  assign advance = holdValid && outRdEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= decodeMode(cfgNarrow, cfgByte);
      bigEndQ   <= cfgBigEnd;
      holdValid <= 1'b0;
      partCnt   <= '0;
    end else if (load) begin
      holdValid <= 1'b1;
      partCnt   <= '0;
    end else if (advance) begin
      if (partCnt == lastIdx) begin
        holdValid <= 1'b0;
        partCnt   <= '0;
      end else begin
        partCnt <= partCnt + 1'b1;
      end
    end
  end

  assign inReady  = !holdValid;
  assign outValid = holdValid;

  always_comb begin
    ctl.load = load;
    ctl.show = holdValid;
    ctl.mode = modeQ;
    ctl.sel  = bigEndQ ? SEL_W'(lastIdx - partCnt) : partCnt;
  end
endmodule

// File: rtl/bus_width_matcher_dpath.sv
module bus_width_matcher_dpath
  import bus_width_matcher_pkg::*;
#(
  parameter int PART_W = 9,
  localparam int WORD_W = PARTS * PART_W,
  localparam int HALF_W = 2 * PART_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [WORD_W-1:0] inData,
  output logic [WORD_W-1:0] outData
);
  logic [WORD_W-1:0] holdWord;
  logic [PART_W-1:0] byteSlice [PARTS];
  logic [HALF_W-1:0] halfSlice [PARTS/2];

  always_ff @(posedge clk) begin
    if (!rstN)         holdWord <= '0;
    else if (ctl.load) holdWord <= inData;
  end

  for (genvar k = 0; k < PARTS; k++) begin : g_byte
    assign byteSlice[k] = holdWord[k*PART_W +: PART_W];
  end
  for (genvar k = 0; k < PARTS/2; k++) begin : g_half
    assign halfSlice[k] = holdWord[k*HALF_W +: HALF_W];
  end

  always_comb begin
    outData = '0;
    if (ctl.show) begin
      unique case (ctl.mode)
        MODE_HALF: outData = WORD_W'(halfSlice[ctl.sel[0]]);
        MODE_BYTE: outData = WORD_W'(byteSlice[ctl.sel]);
        default:   outData = holdWord;
      endcase
    end
  end
endmodule

// File: rtl/bus_width_matcher.sv
module bus_width_matcher
  import bus_width_matcher_pkg::*;
#(
  parameter int PART_W = 9,
  localparam int WORD_W = PARTS * PART_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgNarrow,
  input  logic              cfgByte,
  input  logic              cfgBigEnd,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  output logic              inReady,
  input  logic              outRdEn,
  output logic              outValid,
  output logic [WORD_W-1:0] outData
);
  ctlStrobes_t ctl;

  bus_width_matcher_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgNarrow(cfgNarrow), .cfgByte(cfgByte),
    .cfgBigEnd(cfgBigEnd), .inValid(inValid), .outRdEn(outRdEn),
    .inReady(inReady), .outValid(outValid), .ctl(ctl)
  );

  bus_width_matcher_dpath #(.PART_W(PART_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .outData(outData)
  );
endmodule

// File: rtl/bus_width_matcher_chk.sv
module bus_width_matcher_chk
  import bus_width_matcher_pkg::*;
#(
  parameter int PART_W = 9,
  localparam int WORD_W = PARTS * PART_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgNarrow,
  input logic              cfgByte,
  input logic              inValid,
  input logic              inReady,
  input logic              outRdEn,
  input logic              outValid,
  input logic [WORD_W-1:0] outData
);
  widthMode_t chkMode;
  logic [1:0] readCnt;
  logic [1:0] chkLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkMode <= decodeMode(cfgNarrow, cfgByte);
      readCnt <= '0;
    end else if (inValid && inReady) begin
      readCnt <= '0;
    end else if (outValid && outRdEn) begin
      readCnt <= readCnt + 1'b1;
    end
  end

  assign chkLast = (chkMode == MODE_BYTE) ? 2'd3 : (chkMode == MODE_HALF) ? 2'd1 : 2'd0;

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> outData == '0);
  assert_load_offers_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);
  assert_half_upper_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && chkMode == MODE_HALF |-> outData[WORD_W-1:2*PART_W] == '0);
  assert_byte_upper_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && chkMode == MODE_BYTE |-> outData[WORD_W-1:PART_W] == '0);
  assert_no_early_fetch_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outRdEn && readCnt != chkLast |=> outValid && !inReady);
  assert_release_by_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> $past(outRdEn));
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outRdEn |=> outValid && $stable(outData));
endmodule

bind bus_width_matcher bus_width_matcher_chk #(.PART_W(PART_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgNarrow(cfgNarrow), .cfgByte(cfgByte),
  .inValid(inValid), .inReady(inReady), .outRdEn(outRdEn),
  .outValid(outValid), .outData(outData)
);

// File: tb/bus_width_matcher_test.sv
module bus_width_matcher_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgNarrow = 1'b0, cfgByte = 1'b0, cfgBigEnd = 1'b0;
  logic        inValid = 1'b0;
  logic [35:0] inData = '0;
  logic        inReady;
  logic        outRdEn = 1'b0;
  logic        outValid;
  logic [35:0] outData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  localparam logic [35:0] WORD_A = {9'h1A5, 9'h0C3, 9'h17E, 9'h042};
  localparam logic [35:0] WORD_B = {9'h0F1, 9'h122, 9'h033, 9'h1C4};

  always #10 clk = ~clk;

  bus_width_matcher uut (
    .clk(clk), .rstN(rstN), .cfgNarrow(cfgNarrow), .cfgByte(cfgByte),
    .cfgBigEnd(cfgBigEnd), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outRdEn(outRdEn), .outValid(outValid), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic n, input logic b, input logic be);
    @(negedge clk);
    rstN = 1'b0; cfgNarrow = n; cfgByte = b; cfgBigEnd = be;
    inValid = 1'b0; outRdEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pushWord(input logic [35:0] w, input string req);
    check(inReady === 1'b1, req, 36'(inReady), 36'd1);
    inValid = 1'b1; inData = w;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic readPart(input logic [35:0] exp, input string req);
    check(outValid === 1'b1, req, 36'(outValid), 36'd1);
    check(outData === exp, req, outData, exp);
    outRdEn = 1'b1;
    @(negedge clk);
    outRdEn = 1'b0;
  endtask

  function automatic logic [35:0] half(input logic [35:0] w, input int k);
    return 36'(w[k*18 +: 18]);
  endfunction
  function automatic logic [35:0] byt(input logic [35:0] w, input int k);
    return 36'(w[k*9 +: 9]);
  endfunction

  task automatic testReset();
    doReset(1'b1, 1'b1, 1'b0);
    check(outValid === 1'b0, "R1 valid", 36'(outValid), 36'd0);
    check(inReady === 1'b1, "R1 ready", 36'(inReady), 36'd1);
    check(outData === '0, "R1 data", outData, '0);
  endtask

  task automatic testFull();
    doReset(1'b0, 1'b0, 1'b1);
    pushWord(WORD_A, "R2 ready");
    readPart(WORD_A, "R2 full word");
    check(inReady === 1'b1 && outValid === 1'b0, "R2 released", 36'(inReady), 36'd1);
  endtask

  task automatic testHalf(input logic be);
    doReset(1'b1, 1'b0, be);
    pushWord(WORD_A, "R3 ready");
    for (int k = 0; k < 2; k++)
      readPart(half(WORD_A, be ? 1 - k : k), be ? "R3 R5 R7 half big" : "R3 R6 R7 half little");
    check(outValid === 1'b0, "R3 done", 36'(outValid), 36'd0);
  endtask

  task automatic testByte(input logic be);
    doReset(1'b1, 1'b1, be);
    pushWord(WORD_B, "R4 ready");
    for (int k = 0; k < 4; k++)
      readPart(byt(WORD_B, be ? 3 - k : k), be ? "R4 R5 R7 byte big" : "R4 R6 R7 byte little");
    check(outValid === 1'b0, "R4 done", 36'(outValid), 36'd0);
  endtask

  task automatic testNoEarlyFetch();
    doReset(1'b1, 1'b1, 1'b0);
    pushWord(WORD_A, "R8 first");
    inValid = 1'b1; inData = WORD_B;
    for (int k = 0; k < 3; k++) begin
      check(inReady === 1'b0, "R8 held", 36'(inReady), 36'd0);
      readPart(byt(WORD_A, k), "R8 part of old word");
    end
    check(inReady === 1'b0, "R8 before last", 36'(inReady), 36'd0);
    readPart(byt(WORD_A, 3), "R8 last part");
    check(inReady === 1'b1, "R8 freed", 36'(inReady), 36'd1);
    @(negedge clk);
    inValid = 1'b0;
    readPart(byt(WORD_B, 0), "R8 next word");
  endtask

  task automatic testStall();
    doReset(1'b1, 1'b0, 1'b1);
    outRdEn = 1'b1;
    repeat (2) @(negedge clk);
    outRdEn = 1'b0;
    check(outValid === 1'b0 && outData === '0, "R10 empty read", outData, '0);
    pushWord(WORD_B, "R10 ready");
    repeat (4) @(negedge clk);
    check(outData === half(WORD_B, 1), "R10 stall hold", outData, half(WORD_B, 1));
    readPart(half(WORD_B, 1), "R10 first after stall");
    readPart(half(WORD_B, 0), "R10 second");
  endtask

  task automatic testFrozenConfig();
    doReset(1'b1, 1'b1, 1'b0);
    cfgNarrow = 1'b0; cfgByte = 1'b0; cfgBigEnd = 1'b1;
    @(negedge clk);
    pushWord(WORD_A, "R9 ready");
    for (int k = 0; k < 4; k++) readPart(byt(WORD_A, k), "R9 frozen config");
  endtask

  task automatic testResetMidWord();
    doReset(1'b1, 1'b1, 1'b1);
    pushWord(WORD_A, "R1 mid ready");
    readPart(byt(WORD_A, 3), "R1 mid first");
    doReset(1'b1, 1'b1, 1'b1);
    check(outValid === 1'b0 && inReady === 1'b1, "R1 mid discard", 36'(outValid), 36'd0);
    check(outData === '0, "R1 mid data", outData, '0);
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testFull();
    testHalf(1'b0);
    testHalf(1'b1);
    testByte(1'b0);
    testByte(1'b1);
    testNoEarlyFetch();
    testStall();
    testFrozenConfig();
    testResetMidWord();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule